// File: doc/BRIEF.md
# Cascaded Dual Priority Interrupt Controller

This block joins two eight-input priority interrupt controllers into one request path for a processor. The second controller's request output is wired into input 2 of the first, so fifteen raw lines can interrupt. The raw line numbered 2 has no source behind it. Each controller holds three per-input bit registers: a pending-request register, an in-service register and a mask register. It resolves requests by fixed priority and raises a single `intr` output toward the processor.

Lines named in a parameter are inverted on entry, so a high level inside the block always means "active". A trigger register selects edge or level detection for each line. Lines 0, 2 and 8 stay in edge mode whatever is written. The processor answers `intr` with a one-cycle `ack` strobe. The block expands this into two internal acknowledge pulses. The first pulse freezes the priority decision and moves the winner from pending to in-service. The second pulse presents the 8-bit vector, which is a 5-bit per-controller base followed by the 3-bit input number. Software retires a handler with a non-specific end-of-interrupt command to each controller involved.

Top module: `cascaded_irq_ctrl`

## Requirements
- R1: After reset `intr` and `vec_valid` are low, both mask registers are all ones (every input masked), every trigger bit selects edge mode, the master base is 5'h01 and the slave base is 5'h0E.
- R2: In edge mode (trigger bit 0) a pending bit is set by a low-to-high change of the effective input. An input held high after its acknowledge raises no new request.
- R3: Trigger bit i = 1 selects level mode for line i: the pending bit follows the effective input while it is high and drops when it falls. Writes to trigger bits 0, 2 and 8 have no effect, and those lines remain edge triggered.
- R4: A line whose bit is set in the ACTIVE_LOW parameter (default only line 8) is inverted on entry, so driving it low is a request.
- R5: A set mask bit keeps its input from raising `intr`. The pending bit still latches while masked, and it raises `intr` once the mask bit is written to 0.
- R6: Within each controller input 0 has the highest priority and input 7 the lowest. The whole slave takes the priority slot of master input 2. `intr` is high only when an unmasked pending request outranks every in-service bit on its path.
- R7: An `ack` is accepted only when no acknowledge sequence is in progress. `vec_valid` pulses for exactly one cycle, two rising edges after the edge that samples `ack`. An `ack` arriving during a sequence is ignored.
- R8: The vector is {base, input number}, with the base in bits 7:3. For a slave winner the slave base and slave input number are used, and the master in-service bit 2 is set too. `base_we_m`/`base_we_s` load `base_wdata` into the master or slave base.
- R9: The first internal pulse sets the winning in-service bit and clears its pending bit. That line cannot raise `intr` again until its in-service bit is released.
- R10: If nothing wins at the first internal pulse, the vector is {master base, 3'd7} and no in-service or pending bit changes.
- R11: `eoi_m`/`eoi_s` clear the highest-priority set in-service bit of the master/slave. A slave interrupt needs one command to each controller before lower-or-equal slave requests can be served.
- R12: Raw input 2 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Raw request lines; 0-7 master, 8-15 slave |
| trig_we | input | 1 | Load trigger-mode register |
| trig_wdata | input | 16 | Trigger-mode data, 1 = level |
| mask_we_m | input | 1 | Load master mask register |
| mask_we_s | input | 1 | Load slave mask register |
| mask_wdata | input | 8 | Mask data, 1 = masked |
| base_we_m | input | 1 | Load master vector base |
| base_we_s | input | 1 | Load slave vector base |
| base_wdata | input | 5 | Vector base data |
| eoi_m | input | 1 | Non-specific end of interrupt, master |
| eoi_s | input | 1 | Non-specific end of interrupt, slave |
| ack | input | 1 | Processor acknowledge strobe |
| intr | output | 1 | Interrupt request to processor |
| vec_valid | output | 1 | One-cycle vector strobe |
| vec | output | 8 | Interrupt vector |

## Verification
A request edge on an unmasked line shows on `intr` right after the rising edge that samples it. Mask, trigger and end-of-interrupt writes also take effect after one edge. The vector strobe arrives two edges after the edge that samples `ack`. The bench drives inputs on falling edges, steps a behavioural model on each rising edge, and compares `intr`, `vec_valid` and `vec` with that model on every following falling edge. The acknowledge task counts falling edges from the strobe to `vec_valid` and expects exactly three.

// File: rtl/cic_pkg.sv
package cic_pkg;
   localparam int unsigned CIC_N     = 8;
   localparam int unsigned CIC_IDX_W = $clog2(CIC_N);

   typedef logic [CIC_IDX_W-1:0] cic_idx_t;

   typedef struct packed {
      logic     hit;
      cic_idx_t idx;
   } cic_pick_t;

   // lowest set index wins (index 0 = highest priority)
   function automatic cic_pick_t cic_first(input logic [CIC_N-1:0] v);
      cic_pick_t r;
      r = '0;
      for (int i = CIC_N - 1; i >= 0; i--) begin
         if (v[i]) begin
            r.hit = 1'b1;
            r.idx = cic_idx_t'(i);
         end
      end
      return r;
   endfunction
endpackage

// File: rtl/cic_request.sv
module cic_request #(
   parameter int unsigned LINES      = 16,
   parameter logic [LINES-1:0] ACTIVE_LOW = '0,
   parameter logic [LINES-1:0] FIXED_EDGE = '0,
   parameter logic [LINES-1:0] UNUSED     = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] raw,
   input  logic [LINES-1:0] lvl_cfg,
   input  logic [LINES-1:0] clr,
   output logic [LINES-1:0] irr
);
   logic [LINES-1:0] eff, lvl, prev_q, irr_q;

   assign eff = (raw ^ ACTIVE_LOW) & ~UNUSED;
   assign lvl = lvl_cfg & ~FIXED_EDGE;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q[g] <= 1'b0;
            irr_q[g]  <= 1'b0;
         end else begin
            prev_q[g] <= eff[g];
            if (lvl[g])
               irr_q[g] <= eff[g] & ~clr[g];
            else
               irr_q[g] <= (irr_q[g] | (eff[g] & ~prev_q[g])) & ~clr[g];
         end
      end
   end

   assign irr = irr_q;

   AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr & ~lvl)) |=> ((irr_q & $past(clr & ~lvl)) == '0)); // R9
endmodule

// File: rtl/cic_ack_seq.sv
module cic_ack_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pulse1,
   output logic pulse2
);
   logic p1_q, p2_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p1_q <= 1'b0;
         p2_q <= 1'b0;
      end else begin
         p1_q <= ack & ~p1_q & ~p2_q;
         p2_q <= p1_q;
      end
   end

   assign pulse1 = p1_q;
   assign pulse2 = p2_q;

   AST_SEQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({p1_q, p2_q})); // R7
   AST_SEQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      p1_q |=> p2_q); // R7
endmodule

// File: rtl/cic_unit.sv
module cic_unit
   import cic_pkg::*;
#(
   parameter int unsigned BASE_W   = 5,
   parameter int unsigned BASE_RST = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CIC_N-1:0]  req,
   input  logic              mask_we,
   input  logic [CIC_N-1:0]  mask_wdata,
   input  logic              base_we,
   input  logic [BASE_W-1:0] base_wdata,
   input  logic              eoi,
   input  logic              take,
   output logic              int_out,
   output cic_idx_t          win,
   output logic [BASE_W-1:0] base
);
   logic [CIC_N-1:0]  imr_q, isr_q, pend, eoi_clr, take_set;
   logic [BASE_W-1:0] base_q;
   cic_pick_t         pp, ps;

   assign pend = req & ~imr_q;
   assign pp   = cic_first(pend);
   assign ps   = cic_first(isr_q);

   assign int_out  = pp.hit && (!ps.hit || (pp.idx < ps.idx));
   assign eoi_clr  = (eoi && ps.hit) ? (CIC_N'(1) << ps.idx) : '0;
   assign take_set = take ? (CIC_N'(1) << pp.idx) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imr_q  <= '1;
         isr_q  <= '0;
         base_q <= BASE_W'(BASE_RST);
      end else begin
         if (mask_we) imr_q <= mask_wdata;
         if (base_we) base_q <= base_wdata;
         isr_q <= (isr_q & ~eoi_clr) | take_set;
      end
   end

   assign win  = pp.idx;
   assign base = base_q;

   AST_TAKE_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> isr_q[$past(pp.idx)]); // R9
   AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && ps.hit && !take) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R11
endmodule

// File: rtl/cascaded_irq_ctrl.sv
module cascaded_irq_ctrl
   import cic_pkg::*;
#(
   parameter logic [2*CIC_N-1:0] ACTIVE_LOW = 16'h0100,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned CASC       = 2,
   parameter int unsigned M_BASE_RST = 1,
   parameter int unsigned S_BASE_RST = 14
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] irq_in,
   input  logic        trig_we,
   input  logic [15:0] trig_wdata,
   input  logic        mask_we_m,
   input  logic        mask_we_s,
   input  logic [7:0]  mask_wdata,
   input  logic        base_we_m,
   input  logic        base_we_s,
   input  logic [4:0]  base_wdata,
   input  logic        eoi_m,
   input  logic        eoi_s,
   input  logic        ack,
   output logic        intr,
   output logic        vec_valid,
   output logic [7:0]  vec
);
   localparam int unsigned LINES  = 2 * CIC_N;
   localparam int unsigned BASE_W = VEC_W - CIC_IDX_W;
   localparam logic [LINES-1:0] CASC_LINE  = LINES'(1) << CASC;
   localparam logic [LINES-1:0] FIXED_EDGE = LINES'(1) | CASC_LINE | (LINES'(1) << CIC_N);
   localparam logic [CIC_N-1:0] CASC_BIT   = CIC_N'(1) << CASC;

   if (VEC_W != 8) begin : g_bad_vec
      $error("VEC_W must be 8");
   end
   if (CASC >= CIC_N || CASC == 0) begin : g_bad_casc
      $error("CASC must name a master input 1..7");
   end

   logic [LINES-1:0]  trig_q, irr, clr;
   logic [CIC_N-1:0]  req_m, req_s;
   logic              m_int, s_int, p1, p2, take_m, take_s;
   cic_idx_t          m_win, s_win;
   logic [BASE_W-1:0] m_base, s_base;
   logic [VEC_W-1:0]  hold_q, vec_q;
   logic              vv_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       trig_q <= '0;
      else if (trig_we) trig_q <= trig_wdata & ~FIXED_EDGE;
   end

   cic_request #(
      .LINES(LINES), .ACTIVE_LOW(ACTIVE_LOW),
      .FIXED_EDGE(FIXED_EDGE), .UNUSED(CASC_LINE)
   ) u_req (
      .clk(clk), .rst_n(rst_n), .raw(irq_in), .lvl_cfg(trig_q),
      .clr(clr), .irr(irr)
   );

   assign req_s = irr[LINES-1:CIC_N];
   assign req_m = (irr[CIC_N-1:0] & ~CASC_BIT) | (s_int ? CASC_BIT : '0);

   cic_unit #(.BASE_W(BASE_W), .BASE_RST(S_BASE_RST)) u_slave (
      .clk(clk), .rst_n(rst_n), .req(req_s),
      .mask_we(mask_we_s), .mask_wdata(mask_wdata),
      .base_we(base_we_s), .base_wdata(base_wdata),
      .eoi(eoi_s), .take(take_s),
      .int_out(s_int), .win(s_win), .base(s_base)
   );

   cic_unit #(.BASE_W(BASE_W), .BASE_RST(M_BASE_RST)) u_master (
      .clk(clk), .rst_n(rst_n), .req(req_m),
      .mask_we(mask_we_m), .mask_wdata(mask_wdata),
      .base_we(base_we_m), .base_wdata(base_wdata),
      .eoi(eoi_m), .take(take_m),
      .int_out(m_int), .win(m_win), .base(m_base)
   );

   cic_ack_seq u_seq (
      .clk(clk), .rst_n(rst_n), .ack(ack), .pulse1(p1), .pulse2(p2)
   );

   // first pulse: freeze the decision and commit it
   assign take_m = p1 & m_int;
   assign take_s = take_m & (m_win == cic_idx_t'(CASC));

   always_comb begin
      clr = '0;
      if (take_s)      clr = LINES'(1) << (CIC_N + 32'(s_win));
      else if (take_m) clr = LINES'(1) << m_win;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         vec_q  <= '0;
         vv_q   <= 1'b0;
      end else begin
         if (p1) begin
            if (take_s)      hold_q <= {s_base, s_win};
            else if (take_m) hold_q <= {m_base, m_win};
            else             hold_q <= {m_base, {CIC_IDX_W{1'b1}}};
         end
         vv_q <= p2;
         if (p2) vec_q <= hold_q;
      end
   end

   assign intr      = m_int;
   assign vec_valid = vv_q;
   assign vec       = vec_q;

   AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |=> !vec_valid); // R7
   AST_SLAVE_NEEDS_CASC: assert property (@(posedge clk) disable iff (!rst_n)
      take_s |=> $past(s_int)); // R8
endmodule

// File: tb/cascaded_irq_ctrl_tb.sv
module cascaded_irq_ctrl_tb;
   localparam logic [15:0] AL    = 16'h0100;
   localparam logic [15:0] FIXED = 16'h0105;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic [15:0] irq_in = AL;
   logic        trig_we = 0, mask_we_m = 0, mask_we_s = 0, base_we_m = 0, base_we_s = 0;
   logic [15:0] trig_wdata = '0;
   logic [7:0]  mask_wdata = '0;
   logic [4:0]  base_wdata = '0;
   logic        eoi_m = 0, eoi_s = 0, ack = 0;
   logic        intr, vec_valid;
   logic [7:0]  vec;

   cascaded_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .trig_we(trig_we), .trig_wdata(trig_wdata),
      .mask_we_m(mask_we_m), .mask_we_s(mask_we_s), .mask_wdata(mask_wdata),
      .base_we_m(base_we_m), .base_we_s(base_we_s), .base_wdata(base_wdata),
      .eoi_m(eoi_m), .eoi_s(eoi_s), .ack(ack),
      .intr(intr), .vec_valid(vec_valid), .vec(vec)
   );

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit [15:0] m_irr, m_prev, m_lvl;
   bit [7:0]  m_isr_m, m_isr_s, m_imr_m, m_imr_s, m_hold, m_vec;
   bit [4:0]  m_bm, m_bs;
   bit        m_p1, m_p2, m_vv;

   function automatic int pick(bit [7:0] rq, bit [7:0] isr, bit [7:0] imr);
      for (int i = 0; i < 8; i++) begin
         if (isr[i]) return -1;
         if (rq[i] && !imr[i]) return i;
      end
      return -1;
   endfunction

   function automatic int s_pick();
      return pick(m_irr[15:8], m_isr_s, m_imr_s);
   endfunction

   function automatic int m_pick();
      bit [7:0] rq;
      rq = m_irr[7:0];
      rq[2] = (s_pick() >= 0);
      return pick(rq, m_isr_m, m_imr_m);
   endfunction

   task automatic model_step();
      int mw, sw;
      bit [15:0] eff, clr, nirr;
      bit [7:0] nim, nis;
      bit np1;
      if (!rst_n) begin
         m_irr = 0; m_prev = 0; m_lvl = 0; m_isr_m = 0; m_isr_s = 0;
         m_imr_m = 8'hff; m_imr_s = 8'hff; m_bm = 5'h01; m_bs = 5'h0e;
         m_p1 = 0; m_p2 = 0; m_vv = 0; m_hold = 0; m_vec = 0;
         return;
      end
      mw = m_pick(); sw = s_pick();
      clr = 0; nim = m_isr_m; nis = m_isr_s;
      if (eoi_m) for (int i = 0; i < 8; i++) if (nim[i]) begin nim[i] = 0; break; end
      if (eoi_s) for (int i = 0; i < 8; i++) if (nis[i]) begin nis[i] = 0; break; end
      if (m_p1) begin
         if (mw < 0) m_hold = {m_bm, 3'd7};
         else if (mw == 2) begin
            m_hold = {m_bs, sw[2:0]}; nim[2] = 1; nis[sw] = 1; clr[8+sw] = 1;
         end else begin
            m_hold = {m_bm, mw[2:0]}; nim[mw] = 1; clr[mw] = 1;
         end
      end
      eff = irq_in ^ AL; eff[2] = 0;
      for (int i = 0; i < 16; i++) begin
         if (m_lvl[i]) nirr[i] = eff[i];
         else nirr[i] = m_irr[i] | (eff[i] & !m_prev[i]);
         if (clr[i]) nirr[i] = 0;
      end
      m_vv = m_p2;
      if (m_p2) m_vec = m_hold;
      np1 = ack && !m_p1 && !m_p2;
      m_p2 = m_p1; m_p1 = np1;
      m_irr = nirr; m_prev = eff; m_isr_m = nim; m_isr_s = nis;
      if (trig_we) m_lvl = trig_wdata & ~FIXED;
      if (mask_we_m) m_imr_m = mask_wdata;
      if (mask_we_s) m_imr_s = mask_wdata;
      if (base_we_m) m_bm = base_wdata;
      if (base_we_s) m_bs = base_wdata;
   endtask

   always @(posedge clk) model_step();

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R6 model intr", intr, m_pick() >= 0);
         chk("R7 model vec_valid", vec_valid, m_vv);
         if (m_vv) chk("R8 model vec", vec, m_vec);
      end
   end

   // ---------------- stimulus helpers (start/end at negedge) ----------------
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_line(input int i, input bit active);
      irq_in[i] = active ^ AL[i];
   endtask

   task automatic pulse(input int i);
      set_line(i, 1); tick(1); set_line(i, 0); tick(1);
   endtask

   task automatic do_ack(input string tag, output logic [7:0] v);
      int k;
      ack = 1; tick(1); ack = 0; k = 1;
      while (!vec_valid && k < 8) begin tick(1); k++; end
      chk({tag, " R7 latency"}, k, 3);
      v = vec;
   endtask

   task automatic em(); eoi_m = 1; tick(1); eoi_m = 0; endtask
   task automatic es(); eoi_s = 1; tick(1); eoi_s = 0; endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL R7 watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int pulses;
      tick(3);
      rst_n = 1; tick(1);
      chk("R1 reset intr", intr, 0);
      chk("R1 reset vec_valid", vec_valid, 0);

      pulse(3);
      chk("R5 masked after reset", intr, 0);
      mask_wdata = 8'h00; mask_we_m = 1; mask_we_s = 1; tick(1);
      mask_we_m = 0; mask_we_s = 0;
      chk("R5 latched request shows after unmask", intr, 1);
      do_ack("line3", v);
      chk("R8 vector line3", v, 8'h0B);
      chk("R9 in service blocks", intr, 0);

      pulse(3);
      chk("R6 equal priority waits", intr, 0);
      pulse(1);
      chk("R6 higher priority nests", intr, 1);
      do_ack("line1", v);
      chk("R8 vector line1", v, 8'h09);
      em();
      chk("R11 eoi clears only line1", intr, 0);
      em();
      chk("R11 second eoi frees line3", intr, 1);
      do_ack("line3b", v);
      chk("R8 vector line3 again", v, 8'h0B);
      em();

      set_line(8, 1); tick(1);
      chk("R4 inverted line8 drive low", intr, 1);
      chk("R4 raw level low on line8", irq_in[8], 0);
      do_ack("line8", v);
      chk("R8 slave vector line8", v, 8'h70);
      es();
      pulse(10);
      chk("R11 master cascade still in service", intr, 0);
      em();
      chk("R11 both eoi frees slave", intr, 1);
      do_ack("line10", v);
      chk("R8 slave vector line10", v, 8'h72);
      es(); em();
      set_line(8, 0); tick(1);

      pulse(3); pulse(9);
      do_ack("slot", v);
      chk("R6 slave slot beats master 3", v, 8'h71);
      es(); em();
      do_ack("slot2", v);
      chk("R6 master 3 after slave", v, 8'h0B);
      em();

      trig_wdata = 16'h0021; trig_we = 1; tick(1); trig_we = 0;
      set_line(5, 1); tick(1);
      chk("R3 level request", intr, 1);
      ack = 1; set_line(5, 0); tick(1); ack = 0;
      tick(2);
      chk("R10 spurious strobe", vec_valid, 1);
      chk("R10 spurious vector", vec, 8'h0F);
      pulse(6);
      chk("R10 no in-service left by spurious", intr, 1);
      do_ack("line6", v);
      chk("R8 vector line6", v, 8'h0E);
      em();

      set_line(5, 1); tick(1);
      do_ack("line5", v);
      chk("R3 level vector", v, 8'h0D);
      em();
      chk("R3 level re-requests while high", intr, 1);
      set_line(5, 0); tick(1);
      chk("R3 level drops with input", intr, 0);

      set_line(0, 1); tick(1);
      do_ack("line0", v);
      chk("R3 fixed-edge line0 vector", v, 8'h08);
      em(); tick(1);
      chk("R3 line0 stays edge", intr, 0);
      set_line(0, 0);

      set_line(4, 1); tick(1);
      do_ack("line4", v);
      chk("R2 edge vector", v, 8'h0C);
      em(); tick(2);
      chk("R2 held high no retrigger", intr, 0);
      set_line(4, 0); tick(1);

      set_line(2, 1); tick(1); set_line(2, 0); tick(1); set_line(2, 1); tick(2);
      chk("R12 raw line2 ignored", intr, 0);
      set_line(2, 0); tick(1);

      pulse(6);
      pulses = 0;
      ack = 1; tick(2); ack = 0;
      for (int k = 0; k < 8; k++) begin
         if (vec_valid) pulses++;
         tick(1);
      end
      chk("R7 ack during sequence ignored", pulses, 1);
      em();

      base_wdata = 5'h04; base_we_m = 1; tick(1); base_we_m = 0;
      pulse(3);
      do_ack("base", v);
      chk("R8 programmed base", v, 8'h23);
      em(); tick(2);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule